// File: doc/BRIEF.md
# Stepped-Frequency Multi-Channel PWM Generator

This block drives a bank of independent pulse-width-modulated outputs, four by default. Each channel takes an 8-bit frequency byte and an 8-bit duty code. The frequency byte holds a 2-bit step selector and a 6-bit multiplier. The output frequency is the multiplier plus one, times a step frequency of 0.5, 2, 8 or 32 Hz. This covers 0.5 Hz up to 2048 Hz.

Every period is split into 256 equal slices. The duty code D makes the output active for slices 0 through D. The smallest active time is therefore 1/256 of the period, and a 0 % duty cannot be produced. Two shared 8-bit control words supply a polarity-invert bit and an enable bit for each channel. A disabled channel drives a constant low level.

The block sets no timing of its own: a parameter gives the number of system-clock cycles in one slice at the 0.5 Hz base step with a multiplier of one. Configuration words are used as they arrive. A change takes effect at once, without restarting the channel's counters.

Top module: `stepped_pwm_bank`

## Requirements
- R1: For channel i, frequency byte `freq_cfg[8i+7:8i]` carries the step selector in bits 7:6 and the multiplier M in bits 5:0. The slice rate is proportional to (M+1).
- R2: Step codes 0, 1, 2 and 3 select 0.5, 2, 8 and 32 Hz. One period lasts 256*SLICE_DIV/(4^step*(M+1)) clock cycles, and is exact when that quotient is an integer.
- R3: With duty code D, the output is active during slices 0 through D and idle for the rest. D=255 is active for the whole period, and D=0 is active for exactly one slice.
- R4: Polarity bit i+2 of `pol_ctrl` inverts channel i (channels numbered from 0). When it is set, the output is low in active slices and high in idle slices.
- R5: Enable bit i+4 of `en_ctrl` gates channel i. While it is clear, the output is low whatever the polarity and the counters are held at slice 0. After an enabling clock edge, the output shows slice 0 one cycle later.
- R6: Changes to frequency, duty or polarity take effect immediately, without restarting the slice counter.
- R7: A synchronous active-low reset clears all counters, and after the reset edge every output is low.
- R8: Each channel runs from its own configuration. A channel that is disabled stays low while other channels run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_cfg | input | NUM_CH*8 | Per-channel frequency bytes (step 7:6, multiplier 5:0) |
| duty_cfg | input | NUM_CH*8 | Per-channel duty codes |
| pol_ctrl | input | 8 | Polarity-invert bits, channel i at bit i+2 |
| en_ctrl | input | 8 | Enable bits, channel i at bit i+4 |
| pwm_out | output | NUM_CH | Per-channel PWM outputs |

## Verification
The bench measures the period as the distance between rising edges. It also counts high samples over one full period, for several step and multiplier pairs in both polarities. An off-by-one in the slice compare would show up as one slice too many or too few. A wrong rate shift would scale the measured period.

The duty extremes are tested with both polarities. Code 0 must give a single active slice, code 255 a constant level, and inverted 255 a constant low. A design that treated 0 as "off" would fail here.

The bench changes the duty part-way through a period. A design that restarted its counter on a write would show slice 0 at the wrong moment. Disabled-but-inverted channels and swapped control-bit positions show up as stray highs on the wrong output.

// File: rtl/pwm_step_pkg.sv
package pwm_step_pkg;
   localparam int STEP_W  = 2;
   localparam int MULT_W  = 6;
   localparam int CODE_W  = 8;
   localparam int SLICE_W = 8;
   // largest slice-rate increment: 4^3 * 64
   localparam int INC_W   = 2 * ((1 << STEP_W) - 1) + MULT_W + 1;
   localparam int MAX_INC = 1 << (INC_W - 1);
   localparam int CTRL_W  = 8;
   localparam int POL_BASE = 2;
   localparam int EN_BASE  = 4;

   typedef struct packed {
      logic [STEP_W-1:0] step;
      logic [MULT_W-1:0] mult;
   } freq_byte_t;

   function automatic logic [INC_W-1:0] rate_increment(input freq_byte_t f);
      logic [INC_W-1:0] base;
      base = INC_W'(f.mult) + INC_W'(1);
      return base << (2 * f.step);
   endfunction
endpackage

// File: rtl/pwm_slice_tick.sv
module pwm_slice_tick
   import pwm_step_pkg::*;
#(
   parameter int SLICE_DIV = 4096
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [INC_W-1:0] inc,
   output logic             tick
);
   localparam int ACC_W = $clog2(2 * SLICE_DIV);
   localparam logic [ACC_W-1:0] DIV_V = ACC_W'(SLICE_DIV);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic             wrap;

   assign sum  = acc_q + ACC_W'(inc);
   assign wrap = (sum >= DIV_V);
   assign tick = run && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         acc_q <= '0;
      else if (wrap)
         acc_q <= sum - DIV_V;
      else
         acc_q <= sum;
   end

   AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < DIV_V); // R2

   AST_IDLE_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (acc_q == '0)); // R5
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
   import pwm_step_pkg::*;
#(
   parameter int SLICE_DIV = 4096,
   parameter bit REG_OUT   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              pol_inv,
   input  logic [CODE_W-1:0] freq_byte,
   input  logic [CODE_W-1:0] duty_code,
   output logic              pwm_o
);
   logic [INC_W-1:0]   inc;
   logic               tick;
   logic [SLICE_W-1:0] slice_q;
   logic               active;
   logic               level;

   assign inc = rate_increment(freq_byte_t'(freq_byte));

   pwm_slice_tick #(.SLICE_DIV(SLICE_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .inc  (inc),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         slice_q <= '0;
      else if (tick)
         slice_q <= slice_q + SLICE_W'(1);
   end

   assign active = (slice_q <= duty_code);
   assign level  = run && (active ^ pol_inv);

   generate
      if (REG_OUT) begin : g_reg_out
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               out_q <= 1'b0;
            else
               out_q <= level;
         end
         assign pwm_o = out_q;

         AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> !pwm_o); // R5
         AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !pol_inv && duty_code == 8'hFF) |=> pwm_o); // R3
         AST_RESET_OUT_LOW: assert property (@(posedge clk)
            !rst_n |=> !pwm_o); // R7
      end else begin : g_comb_out
         assign pwm_o = level;
      end
   endgenerate

   AST_SLICE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (slice_q == $past(slice_q) + SLICE_W'(1))); // R6
   AST_SLICE_HOLD_OFF: assert property (@(posedge clk)
      (!rst_n || !run) |=> (slice_q == '0)); // R7
endmodule

// File: rtl/stepped_pwm_bank.sv
module stepped_pwm_bank
   import pwm_step_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int SLICE_DIV = 4096,
   parameter bit REG_OUT   = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*CODE_W-1:0] freq_cfg,
   input  logic [NUM_CH*CODE_W-1:0] duty_cfg,
   input  logic [CTRL_W-1:0]        pol_ctrl,
   input  logic [CTRL_W-1:0]        en_ctrl,
   output logic [NUM_CH-1:0]        pwm_out
);
   generate
      if (NUM_CH < 1 || NUM_CH + EN_BASE > CTRL_W) begin : g_bad_ch
         $error("stepped_pwm_bank: NUM_CH out of range");
      end
      if (SLICE_DIV < MAX_INC) begin : g_bad_div
         $error("stepped_pwm_bank: SLICE_DIV below largest rate increment");
      end
   endgenerate

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         pwm_chan_core #(.SLICE_DIV(SLICE_DIV), .REG_OUT(REG_OUT)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (en_ctrl[EN_BASE + ch]),
            .pol_inv  (pol_ctrl[POL_BASE + ch]),
            .freq_byte(freq_cfg[ch*CODE_W +: CODE_W]),
            .duty_code(duty_cfg[ch*CODE_W +: CODE_W]),
            .pwm_o    (pwm_out[ch])
         );
      end
   endgenerate
endmodule

// File: tb/sim_stepped_pwm_bank.sv
module sim_stepped_pwm_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int NVEC = 8;
   // ch, freq byte, duty, invert, expected period, expected high samples
   localparam int VEC [NVEC][6] = '{
      '{0, 8'hFF, 127, 0,   256,  128},
      '{1, 8'hDF,  63, 0,   512,  128},
      '{2, 8'hCF, 191, 1,  1024,  256},
      '{3, 8'hBF,   9, 0,  1024,   40},
      '{0, 8'h9F, 200, 1,  2048,  440},
      '{1, 8'hFF,   1, 0,   256,    2},
      '{2, 8'h7F, 127, 0,  4096, 2048},
      '{3, 8'h3F,  63, 0, 16384, 4096}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH*8-1:0] freq_cfg = '0;
   logic [NCH*8-1:0] duty_cfg = '0;
   logic [7:0] pol_ctrl = '0;
   logic [7:0] en_ctrl = '0;
   logic [NCH-1:0] pwm_out;
   int n_tests = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stepped_pwm_bank #(.NUM_CH(NCH), .SLICE_DIV(4096)) u0 (
      .clk(clk), .rst_n(rst_n), .freq_cfg(freq_cfg), .duty_cfg(duty_cfg),
      .pol_ctrl(pol_ctrl), .en_ctrl(en_ctrl), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic setup(input int ch, input int fb, input int d, input int inv);
      freq_cfg[ch*8 +: 8] = 8'(fb);
      duty_cfg[ch*8 +: 8] = 8'(d);
      pol_ctrl = 8'(inv) << (ch + 2);
      en_ctrl  = 8'd1 << (ch + 4);
   endtask

   task automatic count_high(input int ch, input int n, output int highs);
      highs = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch]) highs++;
      end
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int h;
      repeat (3) @(negedge clk);
      check("R7 reset outputs low", int'(pwm_out), 0);
      rst_n = 1'b1;

      // table walk: period and high time, other channels stay low
      for (int v = 0; v < NVEC; v++) begin
         int ch, per, highs, stray, guard;
         logic prev;
         ch = VEC[v][0];
         @(negedge clk);
         setup(ch, VEC[v][1], VEC[v][2], VEC[v][3]);
         prev = 1'b1;
         guard = 0;
         while (guard < 40000) begin
            @(negedge clk);
            guard++;
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
         end
         per = 0; highs = 0; stray = 0;
         prev = 1'b1;
         while (per < 40000) begin
            @(negedge clk);
            per++;
            if (pwm_out[ch]) highs++;
            if ((pwm_out & ~(4'b1 << ch)) != 0) stray++;
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
         end
         check($sformatf("R1 R2 period vec %0d", v), per, VEC[v][4]);
         check($sformatf("R3 R4 high time vec %0d", v), highs, VEC[v][5]);
         check($sformatf("R8 other channels low vec %0d", v), stray, 0);
         en_ctrl = '0;
      end

      // minimum duty, output shows slice 0 one cycle after enable
      @(negedge clk);
      setup(1, 8'hFF, 0, 0);
      @(negedge clk);
      check("R5 slice 0 after enable", int'(pwm_out[1]), 1);
      count_high(1, 255, h);
      check("R3 duty 0 single slice", h, 0);
      en_ctrl = '0;

      // full duty both polarities
      @(negedge clk);
      setup(2, 8'hFF, 255, 0);
      count_high(2, 256, h);
      check("R3 duty 255 always active", h, 256);
      setup(2, 8'hFF, 255, 1);
      @(negedge clk);
      count_high(2, 256, h);
      check("R4 inverted duty 255 always low", h, 0);
      setup(2, 8'hFF, 0, 1);
      count_high(2, 256, h);
      check("R4 inverted duty 0 high 255 slices", h, 255);

      // disabled but inverted
      @(negedge clk);
      en_ctrl = '0;
      pol_ctrl = 8'b0011_1100;
      @(negedge clk);
      count_high(3, 300, h);
      check("R5 disabled inverted stays low", h, 0);
      check("R5 all outputs low when disabled", int'(pwm_out), 0);

      // mid-period duty change, no restart
      @(negedge clk);
      setup(0, 8'hFF, 127, 0);
      count_high(0, 100, h);
      check("R6 high before change", int'(pwm_out[0]), 1);
      duty_cfg[7:0] = 8'd49;
      @(negedge clk);
      check("R6 new duty applied without restart", int'(pwm_out[0]), 0);
      repeat (155) @(negedge clk);
      check("R6 slice 255 idle", int'(pwm_out[0]), 0);
      @(negedge clk);
      check("R6 counter wraps to slice 0", int'(pwm_out[0]), 1);

      // reset mid-run
      setup(0, 8'hFF, 255, 0);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 reset mid-run output low", int'(pwm_out), 0);
      duty_cfg[7:0] = 8'd0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 restart at slice 0", int'(pwm_out[0]), 1);
      @(negedge clk);
      check("R7 slice 1 idle after restart", int'(pwm_out[0]), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule